// File: doc/BRIEF.md
# Port Role Toggle Controller

This block runs attach detection on its own for a reversible port with two configuration lines. Once enabled with a valid mode, it advertises the source role, the sink role, or alternates between the two. Each toggle cycle lasts two half-periods, and each half-period is counted in ticks of a millisecond timebase. An optional low-power wait can follow each cycle. During the wait the front end is treated as off and terminations are ignored.

Each line has a classification input that reports open, Rd or Ra. A classification counts only after it has stayed unchanged for a set number of consecutive clock samples while toggling. When a qualifying termination is found, the sequencer freezes. It latches which line and which termination stopped it, and it raises a one-cycle interrupt unless that interrupt is masked. The result stays on the outputs until the enable is cleared.

Top module: `role_toggle_ctrl`

## Requirements
- R1: `mode_i` selects the polling behaviour: 2'b11 is source only (`role_src_o`=1), 2'b10 is sink only (`role_src_o`=0), and 2'b01 alternates, starting as source. 2'b00 never leaves idle. The mode is captured when toggling starts.
- R2: While `enable_i` is low, the sequencer is idle from the next cycle. In idle, `active_o`, `done_o`, `irq_o` and both result fields are 0.
- R3: `pwr_save_i` selects the wait after each full toggle cycle: 00 gives no wait, 01 gives DIS_BASE_TICKS ticks, 10 gives 2×DIS_BASE_TICKS ticks and 11 gives 4×DIS_BASE_TICKS ticks. `active_o` is low during the wait.
- R4: With `rd_only_i`=1, only Rd (code 2'b01) stops toggling. With `rd_only_i`=0, Rd or Ra (code 2'b10) stops it. Code 2'b00 is open and 2'b11 is treated as open.
- R5: In alternating mode, each role is held for exactly HALF_TICKS ticks.
- R6: A stop raises `irq_o` for exactly one cycle, in the first cycle of `done_o`, unless `irq_mask_i` was high in the cycle of the stop.
- R7: On a stop, `result_line_o` reads 2'b01 for line 1 and 2'b10 for line 2, and `result_term_o` holds the termination code. Line 1 wins if both lines qualify. The result holds while `done_o` is high.
- R8: With `rd_only_i`=1 and `audio_exit_i`=1, Ra on both lines stops toggling with `result_line_o`=2'b11 and `result_term_o`=Ra. With `audio_exit_i`=0, that case does not stop.
- R9: A termination counts only after STABLE_SAMPLES equal consecutive samples taken while toggling. A shorter pulse does not stop toggling.
- R10: Terminations seen during the power-save wait have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Toggle enable |
| mode_i | input | 2 | Polling mode select |
| pwr_save_i | input | 2 | Wait selection between toggle cycles |
| rd_only_i | input | 1 | Stop on Rd only |
| audio_exit_i | input | 1 | Also stop on Ra on both lines (applies when rd_only_i=1) |
| irq_mask_i | input | 1 | Suppresses the done interrupt |
| tick_i | input | 1 | Single-cycle millisecond tick |
| cc1_term_i | input | 2 | Line 1 classification |
| cc2_term_i | input | 2 | Line 2 classification |
| active_o | output | 1 | Toggling (not waiting, idle or done) |
| role_src_o | output | 1 | Advertised role: 1 source, 0 sink |
| done_o | output | 1 | Stopped on a qualifying termination |
| irq_o | output | 1 | Done interrupt pulse |
| result_line_o | output | 2 | Line that caused the stop |
| result_term_o | output | 2 | Termination that caused the stop |

## Verification
The assertions check a fixed set of rules on every cycle. Clearing the enable forces idle. Mode 00 never starts. The wait counter stays inside its bound. A change of classification resets qualification. The interrupt lasts one cycle, appears only together with done, and respects the mask. The result holds while done is high. Only the bench scenarios can show the rest: the exact half-period and wait lengths in clocks, the qualifier choice for each mix of terminations and settings, the audio case, glitch rejection at the exact sample boundary, and the fact that terminations during a wait are ignored.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [1:0] TERM_RD  = 2'b01;
  localparam logic [1:0] TERM_RA  = 2'b10;
  localparam logic [1:0] MODE_SRC = 2'b11;
  localparam logic [1:0] MODE_SNK = 2'b10;
  localparam logic [1:0] MODE_DRP = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_DONE} seq_st_e;
endpackage

// File: rtl/rtc_filter.sv
module rtc_filter #(
  parameter int SAMPLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] term_i,
  output logic       stable_o,
  output logic [1:0] term_o
);
  localparam int CW = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] CMAX = CW'(SAMPLES - 1);

  logic [1:0]    s_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q   <= 2'b00;
      cnt_q <= '0;
    end else if (!run_i || term_i != s_q) begin
      s_q   <= term_i;
      cnt_q <= '0;
    end else if (cnt_q != CMAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stable_o = run_i && (cnt_q == CMAX);
  assign term_o   = s_q;

  // R9: a changed sample restarts qualification
  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && term_i != s_q) |=> !stable_o);
endmodule

// File: rtl/rtc_seq.sv
module rtc_seq
  import rtc_pkg::*;
#(
  parameter int HALF_TICKS     = 30,
  parameter int DIS_BASE_TICKS = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] pwr_save_i,
  input  logic       tick_i,
  input  logic       hit_i,
  output seq_st_e    st_o,
  output logic       role_src_o
);
  localparam int MAXT = (HALF_TICKS > 4*DIS_BASE_TICKS) ? HALF_TICKS : 4*DIS_BASE_TICKS;
  localparam int TW   = $clog2(MAXT + 1);

  seq_st_e       st_q;
  logic [1:0]    mode_q;
  logic          phase_q;
  logic [TW-1:0] tcnt_q, wait_q, wait_sel;

  always_comb begin
    case (pwr_save_i)
      2'b01:   wait_sel = TW'(DIS_BASE_TICKS);
      2'b10:   wait_sel = TW'(2*DIS_BASE_TICKS);
      default: wait_sel = TW'(4*DIS_BASE_TICKS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= 2'b00;
      phase_q <= 1'b0;
      tcnt_q  <= '0;
      wait_q  <= '0;
    end else if (!enable_i) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
      tcnt_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (mode_i != 2'b00) begin
          st_q    <= ST_RUN;
          mode_q  <= mode_i;
          phase_q <= 1'b0;
          tcnt_q  <= '0;
        end
        ST_RUN: begin
          if (hit_i) st_q <= ST_DONE;
          else if (tick_i) begin
            if (tcnt_q == TW'(HALF_TICKS - 1)) begin
              tcnt_q  <= '0;
              phase_q <= ~phase_q;
              if (phase_q && pwr_save_i != 2'b00) begin
                st_q   <= ST_WAIT;
                wait_q <= wait_sel;
              end
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_WAIT: if (tick_i) begin
          if (tcnt_q == wait_q - 1'b1) begin
            st_q   <= ST_RUN;
            tcnt_q <= '0;
          end else tcnt_q <= tcnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign st_o       = st_q;
  assign role_src_o = (st_q == ST_RUN || st_q == ST_DONE) &&
                      (mode_q == MODE_SRC || (mode_q == MODE_DRP && !phase_q));

  a_r2_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> st_q == ST_IDLE);
  a_r1_invalid_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && mode_i == 2'b00) |=> st_q != ST_RUN);
  a_r3_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_WAIT |-> tcnt_q < wait_q);
endmodule

// File: rtl/role_toggle_ctrl.sv
module role_toggle_ctrl
  import rtc_pkg::*;
#(
  parameter int HALF_TICKS     = 30,
  parameter int DIS_BASE_TICKS = 40,
  parameter int STABLE_SAMPLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] pwr_save_i,
  input  logic       rd_only_i,
  input  logic       audio_exit_i,
  input  logic       irq_mask_i,
  input  logic       tick_i,
  input  logic [1:0] cc1_term_i,
  input  logic [1:0] cc2_term_i,
  output logic       active_o,
  output logic       role_src_o,
  output logic       done_o,
  output logic       irq_o,
  output logic [1:0] result_line_o,
  output logic [1:0] result_term_o
);
  localparam int NLINES = 2;

  seq_st_e    st;
  logic       run, hit, audio;
  logic [1:0] line_in [NLINES];
  logic [1:0] line_f  [NLINES];
  logic       stab [NLINES];
  logic       qual [NLINES];
  logic [1:0] line_q, term_q;
  logic       irq_q;

  assign line_in[0] = cc1_term_i;
  assign line_in[1] = cc2_term_i;
  assign run = (st == ST_RUN);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    rtc_filter #(.SAMPLES(STABLE_SAMPLES)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
      .term_i(line_in[i]), .stable_o(stab[i]), .term_o(line_f[i]));
    assign qual[i] = stab[i] &&
      (line_f[i] == TERM_RD || (!rd_only_i && line_f[i] == TERM_RA));
  end

  assign audio = rd_only_i && audio_exit_i && stab[0] && stab[1] &&
                 line_f[0] == TERM_RA && line_f[1] == TERM_RA;
  assign hit = audio || qual[0] || qual[1];

  rtc_seq #(.HALF_TICKS(HALF_TICKS), .DIS_BASE_TICKS(DIS_BASE_TICKS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .mode_i(mode_i),
    .pwr_save_i(pwr_save_i), .tick_i(tick_i), .hit_i(hit),
    .st_o(st), .role_src_o(role_src_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 2'b00;
      term_q <= 2'b00;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!enable_i || st == ST_IDLE) begin
        line_q <= 2'b00;
        term_q <= 2'b00;
      end else if (run && hit) begin
        irq_q <= !irq_mask_i;
        if (audio) begin
          line_q <= 2'b11;
          term_q <= TERM_RA;
        end else if (qual[0]) begin
          line_q <= 2'b01;
          term_q <= line_f[0];
        end else begin
          line_q <= 2'b10;
          term_q <= line_f[1];
        end
      end
    end
  end

  assign active_o      = run;
  assign done_o        = (st == ST_DONE);
  assign irq_o         = irq_q;
  assign result_line_o = line_q;
  assign result_term_o = term_q;

  a_r6_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r6_irq_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
  a_r6_irq_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(irq_mask_i));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && enable_i) |=> $stable(result_line_o) && $stable(result_term_o));
  a_r2_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !done_o) |=> result_line_o == 2'b00);
endmodule

// File: tb/sim_role_toggle_ctrl.sv
`timescale 1ns/1ps
module sim_role_toggle_ctrl;
  localparam int HALF = 4, DISB = 3, STAB = 3, TP = 4;
  localparam logic [1:0] OPEN = 2'b00, RD = 2'b01, RA = 2'b10;

  logic clk = 0, rst_n = 0;
  logic enable = 0, rd_only = 0, audio_exit = 0, irq_mask = 0, tick = 0;
  logic [1:0] mode = 0, pwr = 0, cc1 = 0, cc2 = 0;
  logic active, role_src, done, irq;
  logic [1:0] res_line, res_term;
  int tests = 0, fails = 0, irq_cnt = 0;

  always #2.5 clk = ~clk;

  role_toggle_ctrl #(.HALF_TICKS(HALF), .DIS_BASE_TICKS(DISB), .STABLE_SAMPLES(STAB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .mode_i(mode), .pwr_save_i(pwr),
    .rd_only_i(rd_only), .audio_exit_i(audio_exit), .irq_mask_i(irq_mask), .tick_i(tick),
    .cc1_term_i(cc1), .cc2_term_i(cc2), .active_o(active), .role_src_o(role_src),
    .done_o(done), .irq_o(irq), .result_line_o(res_line), .result_term_o(res_term));

  initial forever begin
    repeat (TP-1) @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  end

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_res(logic [1:0] t1, logic [1:0] t2, logic rdo, logic aud);
    if (rdo && aud && t1 == RA && t2 == RA) return {2'b11, RA};
    if (t1 == RD || (!rdo && t1 == RA)) return {2'b01, t1};
    if (t2 == RD || (!rdo && t2 == RA)) return {2'b10, t2};
    return 4'b0000;
  endfunction

  function automatic int wait_clks(logic [1:0] p);
    return (p == 2'b01 ? DISB : p == 2'b10 ? 2*DISB : 4*DISB) * TP;
  endfunction

  task automatic stop_all();
    enable = 0; cc1 = OPEN; cc2 = OPEN;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done(int lim);
    for (int i = 0; i < lim && !done; i++) @(negedge clk);
  endtask

  // length in clocks of the next full interval where sig == lvl
  task automatic run_len(input logic want_role, input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 400 && ((want_role ? role_src : active) != lvl); i++) @(negedge clk);
    for (int i = 0; i < 400 && ((want_role ? role_src : active) == lvl); i++) @(negedge clk);
    for (int i = 0; i < 400 && ((want_role ? role_src : active) != lvl); i++) @(negedge clk);
    for (int i = 0; i < 400 && ((want_role ? role_src : active) == lvl); i++) begin
      n++; @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [3:0] e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset active", active, 0);
    chk("R2 reset done", done, 0);
    chk("R2 reset irq", irq, 0);

    // R1 invalid mode
    mode = 2'b00; enable = 1;
    repeat (30) @(negedge clk);
    chk("R1 mode 00 idle", active, 0);
    stop_all();

    // R1 source only
    mode = 2'b11; enable = 1;
    repeat (3) @(negedge clk);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      if (!role_src || !active) n++;
      @(negedge clk);
    end
    chk("R1 source role held", n, 0);
    stop_all();

    // R1 sink only
    mode = 2'b10; enable = 1;
    repeat (3) @(negedge clk);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      if (role_src || !active) n++;
      @(negedge clk);
    end
    chk("R1 sink role held", n, 0);
    stop_all();

    // R5 alternation
    mode = 2'b01; pwr = 0; enable = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 dual starts source", role_src, 1);
    run_len(1, 1, n);
    chk("R5 source half", n, HALF*TP);
    run_len(1, 0, n);
    chk("R5 sink half", n, HALF*TP);
    stop_all();

    // R3 wait intervals
    for (int p = 1; p < 4; p++) begin
      mode = 2'b01; pwr = 2'(p); enable = 1;
      run_len(0, 0, n);
      chk("R3 wait length", n, wait_clks(2'(p)));
      stop_all();
    end

    // R4/R7/R6 Rd on line 1
    irq_cnt = 0;
    pwr = 0; rd_only = 1; mode = 2'b01; enable = 1;
    repeat (5) @(negedge clk);
    cc1 = RD;
    wait_done(50);
    @(negedge clk);
    chk("R4 Rd stops", done, 1);
    chk("R7 line1", res_line, 2'b01);
    chk("R7 term Rd", res_term, RD);
    chk("R6 irq once", irq_cnt, 1);
    repeat (10) @(negedge clk);
    chk("R7 result held", res_line, 2'b01);
    stop_all();
    chk("R2 cleared done", done, 0);
    chk("R2 cleared line", res_line, 0);

    // R4 Ra on line 2, rd_only clear
    rd_only = 0; enable = 1;
    repeat (5) @(negedge clk);
    cc2 = RA;
    wait_done(50);
    chk("R4 Ra stops", done, 1);
    chk("R7 line2", res_line, 2'b10);
    chk("R7 term Ra", res_term, RA);
    stop_all();

    // R4 Ra ignored with rd_only
    rd_only = 1; audio_exit = 1; enable = 1;
    repeat (5) @(negedge clk);
    cc1 = RA;
    repeat (40) @(negedge clk);
    chk("R4 Ra ignored rd_only", done, 0);
    stop_all();

    // R8 audio
    rd_only = 1; audio_exit = 1; enable = 1;
    repeat (5) @(negedge clk);
    cc1 = RA; cc2 = RA;
    wait_done(50);
    chk("R8 audio stop", done, 1);
    chk("R8 audio line", res_line, 2'b11);
    chk("R8 audio term", res_term, RA);
    stop_all();
    audio_exit = 0; enable = 1;
    repeat (5) @(negedge clk);
    cc1 = RA; cc2 = RA;
    repeat (40) @(negedge clk);
    chk("R8 audio off no stop", done, 0);
    stop_all();

    // R9 glitch rejection
    rd_only = 0; enable = 1;
    repeat (5) @(negedge clk);
    cc1 = RD;
    repeat (STAB-1) @(negedge clk);
    cc1 = OPEN;
    repeat (20) @(negedge clk);
    chk("R9 short pulse ignored", done, 0);
    cc1 = RD;
    repeat (STAB) @(negedge clk);
    cc1 = OPEN;
    repeat (5) @(negedge clk);
    chk("R9 full pulse stops", done, 1);
    stop_all();

    // R6 mask
    irq_cnt = 0; irq_mask = 1; enable = 1;
    repeat (5) @(negedge clk);
    cc2 = RD;
    wait_done(50);
    repeat (3) @(negedge clk);
    chk("R6 masked stop", done, 1);
    chk("R6 masked irq", irq_cnt, 0);
    irq_mask = 0;
    stop_all();

    // R10 terminations during wait
    pwr = 2'b11; mode = 2'b01; enable = 1;
    for (int i = 0; i < 400 && active; i++) @(negedge clk);
    for (int i = 0; i < 400 && !active; i++) @(negedge clk);
    for (int i = 0; i < 400 && active; i++) @(negedge clk);
    @(negedge clk);
    cc1 = RD;
    repeat (wait_clks(2'b11) - 8) @(negedge clk);
    cc1 = OPEN;
    repeat (30) @(negedge clk);
    chk("R10 wait ignores Rd", done, 0);
    stop_all();
    pwr = 0;

    // random mixes
    for (int k = 0; k < 30; k++) begin
      logic [1:0] t1, t2;
      t1 = 2'($urandom_range(0, 3));
      t2 = 2'($urandom_range(0, 3));
      rd_only = 1'($urandom_range(0, 1));
      audio_exit = 1'($urandom_range(0, 1));
      mode = 2'($urandom_range(1, 3));
      e = exp_res(t1, t2, rd_only, audio_exit);
      enable = 1;
      repeat (3) @(negedge clk);
      cc1 = t1; cc2 = t2;
      repeat (40) @(negedge clk);
      chk("R4 random done", done, e[3:2] != 0);
      chk("R7 random line", res_line, e[3:2]);
      chk("R7 random term", res_term, e[3:2] != 0 ? e[1:0] : 2'b00);
      stop_all();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule